// File: doc/BRIEF.md
# Page Written Flag Scanner

This block records which physical pages have been modified by user-mode software. Physical memory is split into half blocks of eight pages. Every page has one sticky "written" flag. The flag is set whenever a user-mode write to that page is seen on the observe port. Supervisor software can then find the pages that need saving.

Supervisor software chooses a window of two adjacent half blocks with a select command. A read command captures all sixteen flags of that window in one word. Each read also moves the window forward:

- A plain read moves it by one half block, so the next plain read overlaps the previous one by eight flags.
- A read with the advance qualifier moves it by a whole pair, so a chain of such reads sweeps an allocation of any size without overlap.

A clear-all strobe resets every flag. The memory itself is outside this block.

Top module: `pwf_scanner`

## Requirements
- R1: After reset, rd_valid is 0, rd_data is 0, every flag is clear and the window's low half block is half block 0.
- R2: A cycle with wr_stb high sets the flag of page wr_page. Page p belongs to half block p/8, at offset p%8. A flag stays set until a clear-all.
- R3: sel_stb loads the window's low half block from sel_half, and the high half block becomes (sel_half+1) mod 16. When select and read share a cycle, the read returns the old window and the select decides the new window, overriding any advance.
- R4: One cycle after rd_stb, rd_valid pulses high for one cycle. rd_data[7:0] then holds the low half block's flags and rd_data[15:8] holds the high half block's flags, with offset 0 of each half block at the least significant bit of its byte. rd_data holds its value until the next read.
- R5: An even sel_half value selects a whole block, sel_half/2. A read then returns that block's sixteen pages in page order, lowest page at bit 0.
- R6: A read with rd_adv high moves the window's low half block up by two, modulo 16.
- R7: A read with rd_adv low moves the window's low half block up by one, modulo 16. The next read therefore repeats the previous high byte as its low byte.
- R8: A flag set by a write in the same cycle as a read appears in that read's result.
- R9: clr_all clears every flag. A write in the same cycle as clr_all still sets its page's flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | A user-mode write was observed this cycle |
| wr_page | input | 7 | Physical page number of the observed write |
| sel_stb | input | 1 | Load the window from sel_half |
| sel_half | input | 4 | Half-block number for the window's low half |
| rd_stb | input | 1 | Capture the window's flags |
| rd_adv | input | 1 | Qualifies rd_stb: step by a pair instead of one half |
| clr_all | input | 1 | Clear every written flag |
| rd_data | output | 16 | Captured flags of the window |
| rd_valid | output | 1 | One-cycle pulse: rd_data was updated |

## Verification
Two pairs of functions can land in the same cycle:

- **Write and read.** The bench drives a write to a page inside the current window in the same cycle as the read, and expects that page's bit in the returned word. The same is done for the high half of the window.
- **Clear and write.** The bench drives clr_all together with a write, then reselects the window and expects exactly that one flag to survive.

A select issued in the same cycle as an advancing read is also provoked. The bench expects the captured word to come from the old window and the following read to come from the selected one.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

   // How the window pointer moves on a clock edge
   typedef enum logic [1:0] {
      WSTEP_HOLD = 2'd0,
      WSTEP_ONE  = 2'd1,
      WSTEP_PAIR = 2'd2,
      WSTEP_LOAD = 2'd3
   } win_step_e;

   function automatic win_step_e pick_step(input logic sel, input logic rd, input logic adv);
      if (sel)
         return WSTEP_LOAD;
      else if (rd && adv)
         return WSTEP_PAIR;
      else if (rd)
         return WSTEP_ONE;
      else
         return WSTEP_HOLD;
   endfunction

endpackage

// File: rtl/pwf_flag_store.sv
module pwf_flag_store #(
   parameter int HALF_PAGES = 8,
   parameter int NUM_HALVES = 16,
   localparam int NPAGES = HALF_PAGES * NUM_HALVES,
   localparam int PAGE_W = $clog2(NPAGES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_en,
   input  logic [PAGE_W-1:0] set_page,
   input  logic              clr_all,
   output logic [NPAGES-1:0] flag_q,
   output logic [NPAGES-1:0] flag_eff
);

   for (genvar p = 0; p < NPAGES; p++) begin : g_page
      logic hit;
      assign hit = set_en && (set_page == PAGE_W'(p));

      // A write wins over a same-cycle clear
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flag_q[p] <= 1'b0;
         else if (hit)
            flag_q[p] <= 1'b1;
         else if (clr_all)
            flag_q[p] <= 1'b0;
      end

      // Forwarded view, so a read sees a write of the same cycle
      assign flag_eff[p] = flag_q[p] | hit;
   end

endmodule

// File: rtl/pwf_window_ctl.sv
module pwf_window_ctl
   import pwf_pkg::*;
#(
   parameter int NUM_HALVES = 16,
   localparam int HALF_W = $clog2(NUM_HALVES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_stb,
   input  logic [HALF_W-1:0] sel_half,
   input  logic              rd_stb,
   input  logic              rd_adv,
   output logic [HALF_W-1:0] win_lo,
   output logic [HALF_W-1:0] win_hi
);

   win_step_e step;
   logic [HALF_W-1:0] lo_nxt;

   assign step = pick_step(sel_stb, rd_stb, rd_adv);

   always_comb begin
      unique case (step)
         WSTEP_LOAD: lo_nxt = sel_half;
         WSTEP_PAIR: lo_nxt = win_lo + HALF_W'(2);
         WSTEP_ONE:  lo_nxt = win_lo + HALF_W'(1);
         default:    lo_nxt = win_lo;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_lo <= '0;
      else
         win_lo <= lo_nxt;
   end

   // Power-of-two count: the wrap is the natural overflow
   assign win_hi = win_lo + HALF_W'(1);

endmodule

// File: rtl/pwf_read_port.sv
module pwf_read_port #(
   parameter int HALF_PAGES = 8,
   parameter int NUM_HALVES = 16,
   localparam int NPAGES = HALF_PAGES * NUM_HALVES,
   localparam int HALF_W = $clog2(NUM_HALVES),
   localparam int WORD_W = 2 * HALF_PAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [NPAGES-1:0] flag_eff,
   input  logic [HALF_W-1:0] win_lo,
   input  logic [HALF_W-1:0] win_hi,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);

   logic [HALF_PAGES-1:0] lo_bits;
   logic [HALF_PAGES-1:0] hi_bits;

   always_comb begin
      lo_bits = '0;
      hi_bits = '0;
      for (int h = 0; h < NUM_HALVES; h++) begin
         if (HALF_W'(h) == win_lo)
            lo_bits = flag_eff[h*HALF_PAGES +: HALF_PAGES];
         if (HALF_W'(h) == win_hi)
            hi_bits = flag_eff[h*HALF_PAGES +: HALF_PAGES];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= rd_stb;
         if (rd_stb)
            rd_data <= {hi_bits, lo_bits};
      end
   end

endmodule

// File: rtl/pwf_scanner.sv
module pwf_scanner #(
   parameter int HALF_PAGES = 8,
   parameter int NUM_HALVES = 16,
   localparam int NPAGES = HALF_PAGES * NUM_HALVES,
   localparam int PAGE_W = $clog2(NPAGES),
   localparam int HALF_W = $clog2(NUM_HALVES),
   localparam int WORD_W = 2 * HALF_PAGES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [PAGE_W-1:0] wr_page,
   input  logic              sel_stb,
   input  logic [HALF_W-1:0] sel_half,
   input  logic              rd_stb,
   input  logic              rd_adv,
   input  logic              clr_all,
   output logic [WORD_W-1:0] rd_data,
   output logic              rd_valid
);

   // Elaboration-time parameter checks
   if (NUM_HALVES < 2 || (NUM_HALVES & (NUM_HALVES - 1)) != 0) begin : g_bad_halves
      $error("pwf_scanner: NUM_HALVES must be a power of two >= 2");
   end
   if (HALF_PAGES < 1 || (HALF_PAGES & (HALF_PAGES - 1)) != 0) begin : g_bad_pages
      $error("pwf_scanner: HALF_PAGES must be a power of two");
   end

   logic [NPAGES-1:0] flag_q;
   logic [NPAGES-1:0] flag_eff;
   logic [HALF_W-1:0] win_lo;
   logic [HALF_W-1:0] win_hi;

   pwf_flag_store #(.HALF_PAGES(HALF_PAGES), .NUM_HALVES(NUM_HALVES)) store_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_en   (wr_stb),
      .set_page (wr_page),
      .clr_all  (clr_all),
      .flag_q   (flag_q),
      .flag_eff (flag_eff)
   );

   pwf_window_ctl #(.NUM_HALVES(NUM_HALVES)) win_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sel_stb  (sel_stb),
      .sel_half (sel_half),
      .rd_stb   (rd_stb),
      .rd_adv   (rd_adv),
      .win_lo   (win_lo),
      .win_hi   (win_hi)
   );

   pwf_read_port #(.HALF_PAGES(HALF_PAGES), .NUM_HALVES(NUM_HALVES)) rdp_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_stb   (rd_stb),
      .flag_eff (flag_eff),
      .win_lo   (win_lo),
      .win_hi   (win_hi),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

endmodule

// File: rtl/pwf_scanner_chk.sv
module pwf_scanner_chk #(
   parameter int HALF_PAGES = 8,
   parameter int NUM_HALVES = 16,
   localparam int NPAGES = HALF_PAGES * NUM_HALVES,
   localparam int PAGE_W = $clog2(NPAGES),
   localparam int HALF_W = $clog2(NUM_HALVES),
   localparam int WORD_W = 2 * HALF_PAGES
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic [PAGE_W-1:0] wr_page,
   input logic              sel_stb,
   input logic [HALF_W-1:0] sel_half,
   input logic              rd_stb,
   input logic              rd_adv,
   input logic              clr_all,
   input logic [WORD_W-1:0] rd_data,
   input logic              rd_valid,
   input logic [HALF_W-1:0] win_lo,
   input logic [NPAGES-1:0] flag_q
);

   assert_valid_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb |=> rd_valid);

   assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> (!rd_valid && $stable(rd_data)));

   assert_select_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_stb |=> (win_lo == $past(sel_half)));

   assert_pair_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && rd_adv && !sel_stb) |=> (win_lo == HALF_W'($past(win_lo) + HALF_W'(2))));

   assert_half_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !rd_adv && !sel_stb) |=> (win_lo == HALF_W'($past(win_lo) + HALF_W'(1))));

   assert_write_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |=> flag_q[$past(wr_page)]);

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_all |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   assert_clear_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_all && !wr_stb) |=> (flag_q == '0));

endmodule

bind pwf_scanner pwf_scanner_chk #(.HALF_PAGES(HALF_PAGES), .NUM_HALVES(NUM_HALVES)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .wr_page  (wr_page),
   .sel_stb  (sel_stb),
   .sel_half (sel_half),
   .rd_stb   (rd_stb),
   .rd_adv   (rd_adv),
   .clr_all  (clr_all),
   .rd_data  (rd_data),
   .rd_valid (rd_valid),
   .win_lo   (win_lo),
   .flag_q   (flag_q)
);

// File: tb/pwf_scanner_tb.sv
module pwf_scanner_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int HP = 8;
   localparam int NH = 16;
   localparam int NP = HP * NH;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [6:0]  wr_page = '0;
   logic        sel_stb = 1'b0;
   logic [3:0]  sel_half = '0;
   logic        rd_stb = 1'b0;
   logic        rd_adv = 1'b0;
   logic        clr_all = 1'b0;
   logic [15:0] rd_data;
   logic        rd_valid;

   int n_run = 0;
   int n_fail = 0;
   bit done = 0;

   logic [NP-1:0] m = '0;
   int            ptr = 0;
   logic [15:0]   held = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwf_scanner dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_stb   (wr_stb),
      .wr_page  (wr_page),
      .sel_stb  (sel_stb),
      .sel_half (sel_half),
      .rd_stb   (rd_stb),
      .rd_adv   (rd_adv),
      .clr_all  (clr_all),
      .rd_data  (rd_data),
      .rd_valid (rd_valid)
   );

   function automatic logic [15:0] window(input int lo, input logic [NP-1:0] f);
      logic [15:0] w;
      for (int j = 0; j < HP; j++) begin
         w[j]      = f[lo*HP + j];
         w[HP + j] = f[((lo + 1) % NH)*HP + j];
      end
      return w;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Called at a falling edge; drives one cycle and checks at the next falling edge
   task automatic step(input bit wr, input int wp, input bit sel, input int sh,
                       input bit rd, input bit adv, input bit clr, input string tag);
      logic [NP-1:0] fm;
      logic [15:0]   expd;
      wr_stb = wr; wr_page = 7'(wp);
      sel_stb = sel; sel_half = 4'(sh);
      rd_stb = rd; rd_adv = adv; clr_all = clr;
      fm = m;
      if (wr) fm[wp] = 1'b1;
      expd = window(ptr, fm);
      if (clr) m = '0;
      if (wr) m[wp] = 1'b1;
      if (sel) ptr = sh;
      else if (rd) ptr = (ptr + (adv ? 2 : 1)) % NH;
      @(posedge clk);
      @(negedge clk);
      wr_stb = 0; sel_stb = 0; rd_stb = 0; rd_adv = 0; clr_all = 0;
      if (rd) begin
         chk(rd_valid === 1'b1, "R4 valid pulse", {15'b0, rd_valid}, 16'h1);
         chk(rd_data === expd, tag, rd_data, expd);
         held = expd;
      end else begin
         chk(rd_valid === 1'b0 && rd_data === held, "R4 hold", rd_data, held);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(rd_data === 16'h0 && rd_valid === 1'b0, "R1 reset outputs", rd_data, 16'h0);
      // R1: window starts at half 0 with no flags set
      step(0, 0, 0, 0, 1, 0, 0, "R1 empty window 0");
      step(1, 8, 0, 0, 0, 0, 0, "R2 write");
      step(0, 0, 1, 0, 0, 0, 0, "R3 select");
      step(0, 0, 0, 0, 1, 0, 0, "R1 first flag seen");

      // Exhaustive: each page alone against every window position
      for (int p = 0; p < NP; p++) begin
         step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
         step(1, p, 0, 0, 0, 0, 0, "R2 write");
         for (int h = 0; h < NH; h++) begin
            step(0, 0, 1, h, 0, 0, 0, "R3 select");
            step(0, 0, 0, 0, 1, 0, 0, (h % 2 == 0) ? "R5 block read" : "R4 window read");
         end
      end

      // Sparse pattern, advancing sweep with wrap
      step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
      for (int p = 0; p < NP; p++)
         if ((p * 5 + 3) % 7 < 3) step(1, p, 0, 0, 0, 0, 0, "R2 pattern write");
      step(0, 0, 1, 13, 0, 0, 0, "R3 select");
      for (int k = 0; k < 10; k++) step(0, 0, 0, 0, 1, 1, 0, "R6 pair sweep");

      // Plain reads overlap by one half block, with wrap
      step(0, 0, 1, 12, 0, 0, 0, "R3 select");
      for (int k = 0; k < 6; k++) step(0, 0, 0, 0, 1, 0, 0, "R7 overlap read");

      // Same-cycle write and read
      step(0, 0, 0, 0, 0, 0, 1, "R9 clear");
      step(0, 0, 1, 5, 0, 0, 0, "R3 select");
      step(1, 5*HP + 2, 0, 0, 1, 0, 0, "R8 low half same cycle");
      step(1, 7*HP + 6, 0, 0, 1, 1, 0, "R8 high half same cycle");
      step(0, 0, 1, 6, 0, 0, 0, "R3 select");
      step(0, 0, 0, 0, 1, 0, 0, "R8 flag retained");

      // Select and advancing read in the same cycle
      step(0, 0, 1, 2, 0, 0, 0, "R3 select");
      step(0, 0, 1, 9, 1, 1, 0, "R3 read uses old window");
      step(0, 0, 0, 0, 1, 0, 0, "R3 select beats advance");

      // Clear and write in the same cycle
      step(1, 3, 0, 0, 0, 0, 0, "R2 write");
      step(1, 100, 0, 0, 0, 0, 1, "R9 clear with write");
      step(0, 0, 1, 0, 0, 0, 0, "R3 select");
      step(0, 0, 0, 0, 1, 0, 0, "R9 old flag cleared");
      step(0, 0, 1, 12, 0, 0, 0, "R3 select");
      step(0, 0, 0, 0, 1, 1, 0, "R9 write survives clear");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule